// File: doc/BRIEF.md
# Clocked Floating-Point Adder

This unit adds two 32-bit floating-point words and hands back a 32-bit sum. A caller raises a request with both operands on the inputs. The unit captures them, works for a fixed number of clocks, and then raises done with the result on its output. It holds done until the caller drops the request, and then returns to idle ready for the next one.

Subtraction is not a separate mode. The caller inverts the sign bit of the second operand before making the request. The datapath compares the two magnitudes and aligns the smaller significand to the larger exponent in one step. It then adds or subtracts the significands as signed magnitudes and normalises the total in one step, using a leading-zero count. Bits shifted out are dropped, so rounding is truncation. Results past the top of the exponent range saturate, and results below its bottom flush to zero. Denormals, infinities and NaNs are not given any special meaning.

Both handshake pins are plain four-phase control, with no streaming back-pressure. The caller must keep req high until it sees done, and must then lower req to release the unit.

Top module: `fpadd_unit`

## Requirements
- R1: A word is packed as sign in bit 31, an 8-bit exponent field in bits 30:23 and a 23-bit fraction in bits 22:0, with an implied leading one. An exponent field of 0 means the value is zero. The operands are sampled at the edge that accepts the request, and later changes to opa or opb have no effect on that operation.
- R2: While reset is asserted (rst_n low), done is 0 and result is all zeros.
- R3: When the signs are equal, the significands are added and the result takes the common sign. If the sum carries out, it is shifted right by one with truncation and the exponent rises by one.
- R4: done rises after the fourth rising clock edge, counting the edge at which req is first seen high in idle. This holds for every exponent difference.
- R5: result stays constant for as long as done is high, and it keeps its value after done falls.
- R6: done stays high while req stays high. At the first edge that sees req low while done is high, done falls.
- R7: When the signs differ, the smaller magnitude is subtracted from the larger, and the result takes the sign of the larger. The difference is shifted left by its leading-zero count, and the exponent falls by the same amount.
- R8: An exact cancellation gives the all-zero word (positive zero). A done result with a zero exponent field is always the all-zero word.
- R9: The smaller significand is shifted right by the exponent difference in one step, and the bits shifted out are lost. A difference of 24 or more makes the smaller operand contribute nothing.
- R10: If exactly one operand has a zero exponent field, the result is the other operand word, unchanged. If both operands are zero, the result is all zeros.
- R11: If the exponent would pass 255, the result is the sign followed by all ones in the exponent and fraction fields.
- R12: If normalisation would bring the exponent below 1, the result is the all-zero word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request; held high until done, then lowered |
| opa | input | 32 | First operand word |
| opb | input | 32 | Second operand word; invert bit 31 to subtract |
| done | output | 1 | Result valid; high until req is seen low |
| result | output | 32 | Sum word |

## Verification
A wrong control state shows at the ports within one operation. done rises earlier or later than the fourth edge, stays high after req falls, or never rises, and the bench catches it on the clock where it happens. A fault in alignment, the sum or normalisation shows as a wrong result word on the clock that done rises. Cases that exercise every path are needed to expose it: carry-out, deep cancellation, exponent differences at and beyond the significand width, zero operands, and both clamps.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;
  // Sequencer phases, one clock each
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALIGN,
    ST_SUM,
    ST_NORM,
    ST_HOLD
  } fpadd_state_e;
endpackage

// File: rtl/fpadd_align.sv
module fpadd_align #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1
) (
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  output logic             sign_l,
  output logic [EXP_W-1:0] exp_l,
  output logic [SIG_W-1:0] sig_l,
  output logic [SIG_W-1:0] sig_s_al,
  output logic             eff_sub,
  output logic             bypass,
  output logic [W-1:0]     bypass_word
);
  localparam int SH_W = $clog2(SIG_W);

  logic             a_zero, b_zero, a_big;
  logic [EXP_W-1:0] exp_a, exp_b, exp_s, diff;
  logic [SIG_W-1:0] sig_s;
  logic [SIG_W-1:0] stg [SH_W+1];

  assign exp_a  = opa[W-2 -: EXP_W];
  assign exp_b  = opb[W-2 -: EXP_W];
  assign a_zero = (exp_a == '0);
  assign b_zero = (exp_b == '0);
  assign a_big  = (opa[W-2:0] >= opb[W-2:0]);

  assign sign_l  = a_big ? opa[W-1] : opb[W-1];
  assign exp_l   = a_big ? exp_a : exp_b;
  assign exp_s   = a_big ? exp_b : exp_a;
  assign sig_l   = a_big ? {1'b1, opa[MAN_W-1:0]} : {1'b1, opb[MAN_W-1:0]};
  assign sig_s   = a_big ? {1'b1, opb[MAN_W-1:0]} : {1'b1, opa[MAN_W-1:0]};
  assign eff_sub = opa[W-1] ^ opb[W-1];
  assign diff    = exp_l - exp_s;

  // Logarithmic right shifter: one stage per bit of the difference
  assign stg[0] = sig_s;
  for (genvar i = 0; i < SH_W; i++) begin : g_shift
    assign stg[i+1] = diff[i] ? (stg[i] >> (1 << i)) : stg[i];
  end
  assign sig_s_al = (diff >= EXP_W'(SIG_W)) ? '0 : stg[SH_W];

  assign bypass      = a_zero | b_zero;
  assign bypass_word = (a_zero && b_zero) ? '0 : (a_zero ? opb : opa);
endmodule

// File: rtl/fpadd_sum.sv
module fpadd_sum #(
  parameter int MAN_W = 23,
  localparam int SIG_W = MAN_W + 1
) (
  input  logic [SIG_W-1:0] sig_l,
  input  logic [SIG_W-1:0] sig_s,
  input  logic             eff_sub,
  output logic [SIG_W:0]   sum
);
  // Magnitude of sig_l is never below sig_s, so the difference is non-negative
  assign sum = eff_sub ? ({1'b0, sig_l} - {1'b0, sig_s})
                       : ({1'b0, sig_l} + {1'b0, sig_s});
endmodule

// File: rtl/fpadd_norm.sv
module fpadd_norm #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int LZ_W  = $clog2(SIG_W + 1)
) (
  input  logic             sign_l,
  input  logic [EXP_W-1:0] exp_l,
  input  logic [SIG_W:0]   sum,
  input  logic             bypass,
  input  logic [W-1:0]     bypass_word,
  output logic [W-1:0]     word
);
  logic [LZ_W-1:0]  lz;
  logic [SIG_W-1:0] shl;
  logic [EXP_W:0]   exp_ext, lz_ext, exp_up, exp_dn;
  logic             carry, ovf, unf;

  // Leading-zero count of the low SIG_W bits; highest set bit wins
  always_comb begin
    lz = LZ_W'(SIG_W);
    for (int i = 0; i < SIG_W; i++) begin
      if (sum[i]) lz = LZ_W'(SIG_W - 1 - i);
    end
  end

  assign carry   = sum[SIG_W];
  assign shl     = sum[SIG_W-1:0] << lz;
  assign exp_ext = {1'b0, exp_l};
  assign lz_ext  = (EXP_W+1)'(lz);
  assign exp_up  = exp_ext + 1'b1;
  assign exp_dn  = exp_ext - lz_ext;
  assign ovf     = carry && exp_up[EXP_W];
  assign unf     = !carry && (exp_ext <= lz_ext);

  always_comb begin
    if (bypass) begin
      word = bypass_word;
    end else if (sum == '0) begin
      word = '0;
    end else if (carry) begin
      if (ovf) word = {sign_l, {EXP_W{1'b1}}, {MAN_W{1'b1}}};
      else     word = {sign_l, exp_up[EXP_W-1:0], sum[MAN_W:1]};
    end else if (unf) begin
      word = '0;
    end else begin
      word = {sign_l, exp_dn[EXP_W-1:0], shl[MAN_W-1:0]};
    end
  end
endmodule

// File: rtl/fpadd_unit.sv
module fpadd_unit
  import fpadd_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W     = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         done,
  output logic [W-1:0] result
);
  fpadd_state_e state;

  logic [W-1:0]     cap_a, cap_b;
  // alignment outputs (combinational) and their stage registers
  logic             al_sign, al_sub, al_byp;
  logic [EXP_W-1:0] al_exp;
  logic [SIG_W-1:0] al_sig_l, al_sig_s;
  logic [W-1:0]     al_bw;
  logic             r1_sign, r1_sub, r1_byp;
  logic [EXP_W-1:0] r1_exp;
  logic [SIG_W-1:0] r1_sig_l, r1_sig_s;
  logic [W-1:0]     r1_bw;
  logic [SIG_W:0]   sum_c, r2_sum;
  logic [W-1:0]     norm_w;

  fpadd_align #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_align (
    .opa(cap_a), .opb(cap_b),
    .sign_l(al_sign), .exp_l(al_exp), .sig_l(al_sig_l), .sig_s_al(al_sig_s),
    .eff_sub(al_sub), .bypass(al_byp), .bypass_word(al_bw)
  );

  fpadd_sum #(.MAN_W(MAN_W)) u_sum (
    .sig_l(r1_sig_l), .sig_s(r1_sig_s), .eff_sub(r1_sub), .sum(sum_c)
  );

  fpadd_norm #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .sign_l(r1_sign), .exp_l(r1_exp), .sum(r2_sum),
    .bypass(r1_byp), .bypass_word(r1_bw), .word(norm_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      result <= '0;
    end else begin
      unique case (state)
        ST_IDLE:  if (req) state <= ST_ALIGN;
        ST_ALIGN: state <= ST_SUM;
        ST_SUM:   state <= ST_NORM;
        ST_NORM: begin
          result <= norm_w;
          state  <= ST_HOLD;
        end
        ST_HOLD:  if (!req) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == ST_IDLE && req) begin
      cap_a <= opa;
      cap_b <= opb;
    end
    if (state == ST_ALIGN) begin
      r1_sign  <= al_sign;
      r1_exp   <= al_exp;
      r1_sig_l <= al_sig_l;
      r1_sig_s <= al_sig_s;
      r1_sub   <= al_sub;
      r1_byp   <= al_byp;
      r1_bw    <= al_bw;
    end
    if (state == ST_SUM) r2_sum <= sum_c;
  end

  assign done = (state == ST_HOLD);
endmodule

// File: rtl/fpadd_unit_chk.sv
module fpadd_unit_chk #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         req,
  input logic         done,
  input logic [W-1:0] result
);
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(req, 1) && $past(req, 2) && $past(req, 3) && $past(req, 4)));

  a_r5_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(result));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && req) |=> done);

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req) |=> !done);

  a_r8_zero_form: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result[W-2 -: EXP_W] == '0) |-> (result == '0));
endmodule

bind fpadd_unit fpadd_unit_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .done(done), .result(result)
);

// File: tb/fpadd_unit_test.sv
module fpadd_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic        done;
  logic [31:0] result;
  int          n_chk = 0, n_fail = 0, cyc = 0;
  bit          ended = 1'b0;

  always #5 clk = ~clk;

  fpadd_unit uut (.clk(clk), .rst_n(rst_n), .req(req), .opa(opa), .opb(opb),
                  .done(done), .result(result));

  // Behavioural reference for one addition
  function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y);
    int     ex, ey, el, es, d, e;
    longint ml, ms, r;
    logic   sg;
    ex = int'(x[30:23]);
    ey = int'(y[30:23]);
    if (ex == 0 && ey == 0) return 32'h0;
    if (ex == 0) return y;
    if (ey == 0) return x;
    if (x[30:0] >= y[30:0]) begin
      el = ex; es = ey; sg = x[31];
      ml = longint'({1'b1, x[22:0]}); ms = longint'({1'b1, y[22:0]});
    end else begin
      el = ey; es = ex; sg = y[31];
      ml = longint'({1'b1, y[22:0]}); ms = longint'({1'b1, x[22:0]});
    end
    d = el - es;
    if (d >= 24) ms = 0;
    else ms = ms / (longint'(1) << d);
    r = (x[31] != y[31]) ? ml - ms : ml + ms;
    if (r == 0) return 32'h0;
    e = el;
    while (r >= (longint'(1) << 24)) begin r = r / 2; e++; end
    while (r < (longint'(1) << 23)) begin r = r * 2; e--; end
    if (e > 255) return {sg, 8'hFF, 23'h7FFFFF};
    if (e < 1) return 32'h0;
    return {sg, e[7:0], r[22:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [31:0] x, input logic [31:0] y, input string tag);
    logic [31:0] ew;
    ew = model(x, y);
    @(negedge clk);
    opa = x; opb = y; req = 1'b1;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k == 1) begin opa = ~x; opb = ~y; end // R1: late operand change ignored
      if (k < 4) chk("R4 done low while computing", {31'b0, done}, 32'h0);
      else begin
        chk("R4 done at fourth edge", {31'b0, done}, 32'h1);
        chk(tag, result, ew);
      end
    end
    @(negedge clk);
    chk("R6 done held with req", {31'b0, done}, 32'h1);
    chk("R5 result stable", result, ew);
    req = 1'b0;
    @(negedge clk);
    chk("R6 done released", {31'b0, done}, 32'h0);
    chk("R5 result kept", result, ew);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !ended) begin
      ended = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rs;
    repeat (2) @(negedge clk);
    chk("R2 reset done", {31'b0, done}, 32'h0);
    chk("R2 reset result", result, 32'h0);
    rst_n = 1'b1;
    run_op(32'h3F800000, 32'h3F800000, "R3 equal add with carry");
    run_op(32'h3FC00000, 32'h40200000, "R3 add with carry");
    run_op(32'h3F800000, 32'h3F000000, "R3 add no carry");
    run_op(32'h40400000, 32'hBF800000, "R7 subtract larger first");
    run_op(32'h3F800000, 32'hC0400000, "R7 sign of larger");
    run_op(32'h3F800001, 32'hBF800000, "R7 deep normalise");
    run_op(32'h40490FDB, 32'hC0490FDB, "R8 exact cancel");
    run_op(32'h4B800000, 32'h3F800000, "R9 diff 24 ignored");
    run_op(32'h4B000000, 32'h3F800001, "R9 diff 23 truncated");
    run_op(32'hC7000000, 32'h30000000, "R9 large diff");
    run_op(32'h00000000, 32'hC1200000, "R10 zero first");
    run_op(32'h41200000, 32'h80000000, "R10 zero second");
    run_op(32'h00000000, 32'h80000000, "R10 both zero");
    run_op(32'h7F800000, 32'h7F800000, "R11 overflow positive");
    run_op(32'hFFC00000, 32'hFFC00000, "R11 overflow negative");
    run_op(32'h00800001, 32'h80800000, "R12 underflow");
    rs = 32'h1234_5678;
    for (int i = 0; i < 24; i++) begin
      rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
      run_op(rs, {rs[7:0], rs[31:8]} ^ 32'h0F0F_3C3C, "R1 mixed operands");
    end
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule